// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns bytes into framed characters on one serial line that rests high. Bytes are written into a small transmit queue. From the queue they move into a one-entry holding stage, and from there into the shift register that drives the line. Because of this, the next byte can be staged while the current character is still on the wire. The character format is set at run time: the data length, the parity mode and the stop length. The format is taken when a character starts, so a change during a character has no effect on it.

A new character starts only when two conditions hold. The clear-to-send input must be high, and software flow control must not be paused. Pause and resume requests come from a companion receiver, which presents every received byte for one cycle. The pause code is 0x13 and the resume code is 0x11. Flow control only acts between characters, so a character that has started always runs to the end. Bit timing comes from a half-bit tick counter, which lets the stop field be one and a half bits long.

Top module: `serial_tx_core`

## Requirements
- R1: While no character is in flight, `txd` is 1. Every character begins with one start bit at 0.
- R2: The data field has `cfg_len`+5 bits (`cfg_len` 0 gives 5 bits, 3 gives 8 bits) and is sent least significant bit first, directly after the start bit.
- R3: The parity bit follows the data field. `cfg_par` selects it: 1 gives even parity (data plus parity hold an even number of ones), 2 gives odd parity, and 0 or 3 gives no parity bit.
- R4: The stop field is at 1 and lasts 2 half-bits when `cfg_stop` is 0, 3 half-bits when it is 1, and 4 half-bits when it is 2 or 3. A half-bit lasts HALF_DIV clock cycles, so every whole bit lasts 2*HALF_DIV cycles.
- R5: The format inputs are taken in the cycle a character is loaded. Changing them while a character is in flight does not alter that character.
- R6: The queue holds DEPTH bytes. `fifo_full` is high exactly when it holds DEPTH bytes, and a write while it is full is dropped.
- R7: `hold_empty` is high while the holding stage holds no byte. The holding stage refills from the queue in the cycle after it becomes free. A waiting character is loaded in the first cycle the line is idle, so back-to-back characters are separated by one idle cycle.
- R8: No character starts while `cts` is low. A character that has already started completes.
- R9: When `rx_valid` is high with `rx_byte` equal to 0x13, later character starts are held off until a byte 0x11 arrives. Other bytes have no effect, and the character already in flight completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write one byte into the queue |
| wr_data | input | 8 | Byte to write |
| cfg_len | input | 2 | Data length code (length = code + 5) |
| cfg_par | input | 2 | Parity mode: 0 none, 1 even, 2 odd, 3 none |
| cfg_stop | input | 2 | Stop length: 0 one bit, 1 one and a half bits, 2 or 3 two bits |
| cts | input | 1 | Clear to send; high allows a new character |
| rx_valid | input | 1 | A byte from the companion receiver is present |
| rx_byte | input | 8 | Received byte, checked for pause and resume codes |
| txd | output | 1 | Serial line, idle high |
| fifo_full | output | 1 | Queue is full |
| hold_empty | output | 1 | Holding stage is free (transmitter can take more data) |

## Verification
The bench builds the block with HALF_DIV=3 and DEPTH=4. An odd half-bit length means the one-and-a-half stop field ends in the middle of a bit period, which tests the counter at a point where a simple bit-based count would go wrong. A four-deep queue fills after a few writes, so writes that are dropped while full, and the refill of the holding stage from the queue, can both be reached while `cts` holds the line. Software flow control is built in, so pause and resume can be tested against a character that is in flight.

// File: rtl/stx_pkg.sv
package stx_pkg;

   typedef enum logic [1:0] {
      PAR_NONE = 2'd0,
      PAR_EVEN = 2'd1,
      PAR_ODD  = 2'd2,
      PAR_OFF  = 2'd3
   } par_mode_e;

   typedef enum logic [1:0] {
      STOP_ONE     = 2'd0,
      STOP_ONEHALF = 2'd1,
      STOP_TWO     = 2'd2,
      STOP_TWO_ALT = 2'd3
   } stop_mode_e;

   typedef struct packed {
      logic [1:0] len;
      par_mode_e  par;
      stop_mode_e stop;
   } tx_fmt_t;

   // start + 8 data + parity + 2 stop
   localparam int unsigned FRAME_W = 12;
   // up to 24 half-bits per character
   localparam int unsigned HALF_W  = 5;

endpackage

// File: rtl/stx_fifo.sv
module stx_fifo #(
   parameter int unsigned WIDTH = 8,
   parameter int unsigned DEPTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] din,
   input  logic             pop,
   output logic [WIDTH-1:0] dout,
   output logic             empty,
   output logic             full
);
   localparam int unsigned AW = $clog2(DEPTH);
   localparam int unsigned CW = AW + 1;
   localparam logic [CW-1:0] CNT_MAX = CW'(DEPTH);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("stx_fifo: DEPTH must be a power of two of at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wptr, rptr;
   logic [CW-1:0]    count;
   logic             push_ok, pop_ok;

   assign empty   = (count == '0);
   assign full    = (count == CNT_MAX);
   assign push_ok = push && !full;
   assign pop_ok  = pop && !empty;
   assign dout    = mem[rptr];

   always_ff @(posedge clk) begin
      if (push_ok) mem[wptr] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else begin
         if (push_ok) wptr <= wptr + AW'(1);
         if (pop_ok)  rptr <= rptr + AW'(1);
         case ({push_ok, pop_ok})
            2'b10:   count <= count + CW'(1);
            2'b01:   count <= count - CW'(1);
            default: count <= count;
         endcase
      end
   end

   AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_MAX); // R6
   AST_FIFO_DROP_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop) |=> $stable(count)); // R6

endmodule

// File: rtl/stx_half_tick.sv
module stx_half_tick #(
   parameter int unsigned HALF_DIV = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic half_tick
);
   generate
      if (HALF_DIV < 1) begin : g_bad_div
         $error("stx_half_tick: HALF_DIV must be at least 1");
      end

      if (HALF_DIV == 1) begin : g_every_cycle
         assign half_tick = run;
      end else begin : g_counter
         localparam int unsigned CW = $clog2(HALF_DIV);
         localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);
         logic [CW-1:0] cnt;

         assign half_tick = run && (cnt == LAST);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          cnt <= '0;
            else if (!run)       cnt <= '0;
            else if (half_tick)  cnt <= '0;
            else                 cnt <= cnt + CW'(1);
         end

         AST_TICK_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
            !run |=> !half_tick); // R4
      end
   endgenerate

endmodule

// File: rtl/stx_flow_gate.sv
module stx_flow_gate #(
   parameter bit         FLOW_SW   = 1'b1,
   parameter logic [7:0] PAUSE_CODE  = 8'h13,
   parameter logic [7:0] RESUME_CODE = 8'h11
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cts,
   input  logic       rx_valid,
   input  logic [7:0] rx_byte,
   output logic       allow
);
   logic paused;

   generate
      if (FLOW_SW) begin : g_sw_flow
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               paused <= 1'b0;
            else if (rx_valid && rx_byte == PAUSE_CODE)
               paused <= 1'b1;
            else if (rx_valid && rx_byte == RESUME_CODE)
               paused <= 1'b0;
         end

         AST_PAUSE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            (rx_valid && rx_byte == PAUSE_CODE) |=> !allow); // R9
      end else begin : g_hw_only
         assign paused = 1'b0;
      end
   endgenerate

   assign allow = cts && !paused;

endmodule

// File: rtl/stx_shifter.sv
module stx_shifter
   import stx_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    load,
   input  logic [7:0] data,
   input  tx_fmt_t fmt,
   input  logic    half_tick,
   output logic    busy,
   output logic    txd
);
   logic [FRAME_W-1:0] frame_d, sh;
   logic [HALF_W-1:0]  total_d, total_q, half_cnt;

   always_comb begin
      int   nbits;
      int   stop_h;
      logic ones;
      logic pe;
      nbits   = 5 + int'(fmt.len);
      ones    = ^(data & (8'hFF >> (2'd3 - fmt.len)));
      pe      = (fmt.par == PAR_EVEN) || (fmt.par == PAR_ODD);
      frame_d = '1;
      frame_d[0] = 1'b0;
      for (int i = 0; i < 8; i++) begin
         if (i < nbits) frame_d[i+1] = data[i];
      end
      if (pe) frame_d[nbits+1] = ones ^ (fmt.par == PAR_ODD);
      case (fmt.stop)
         STOP_ONE:     stop_h = 2;
         STOP_ONEHALF: stop_h = 3;
         default:      stop_h = 4;
      endcase
      total_d = HALF_W'(2 * (1 + nbits + int'(pe)) + stop_h);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh       <= '1;
         busy     <= 1'b0;
         total_q  <= '0;
         half_cnt <= '0;
      end else if (load) begin
         sh       <= frame_d;
         busy     <= 1'b1;
         total_q  <= total_d;
         half_cnt <= '0;
      end else if (busy && half_tick) begin
         if (half_cnt == total_q - HALF_W'(1)) begin
            busy     <= 1'b0;
            sh       <= '1;
            half_cnt <= '0;
         end else begin
            half_cnt <= half_cnt + HALF_W'(1);
            if (half_cnt[0]) sh <= {1'b1, sh[FRAME_W-1:1]};
         end
      end
   end

   assign txd = sh[0];

   AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> txd); // R1
   AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !txd); // R1
   AST_FMT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(total_q)); // R5
   AST_NO_LOAD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> !busy); // R7

endmodule

// File: rtl/serial_tx_core.sv
module serial_tx_core
   import stx_pkg::*;
#(
   parameter int unsigned HALF_DIV = 8,
   parameter int unsigned DEPTH    = 4,
   parameter bit          FLOW_SW  = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [7:0] wr_data,
   input  logic [1:0] cfg_len,
   input  logic [1:0] cfg_par,
   input  logic [1:0] cfg_stop,
   input  logic       cts,
   input  logic       rx_valid,
   input  logic [7:0] rx_byte,
   output logic       txd,
   output logic       fifo_full,
   output logic       hold_empty
);
   logic       fifo_empty, fifo_pop;
   logic [7:0] fifo_head;
   logic       hold_valid;
   logic [7:0] hold_data;
   logic       allow, busy, load, half_tick;
   tx_fmt_t    fmt;

   assign fmt = '{len: cfg_len, par: par_mode_e'(cfg_par), stop: stop_mode_e'(cfg_stop)};

   stx_fifo #(.WIDTH(8), .DEPTH(DEPTH)) i_fifo (
      .clk(clk), .rst_n(rst_n),
      .push(wr_en), .din(wr_data),
      .pop(fifo_pop), .dout(fifo_head),
      .empty(fifo_empty), .full(fifo_full)
   );

   stx_flow_gate #(.FLOW_SW(FLOW_SW)) i_gate (
      .clk(clk), .rst_n(rst_n), .cts(cts),
      .rx_valid(rx_valid), .rx_byte(rx_byte), .allow(allow)
   );

   stx_half_tick #(.HALF_DIV(HALF_DIV)) i_tick (
      .clk(clk), .rst_n(rst_n), .run(busy), .half_tick(half_tick)
   );

   assign load     = !busy && hold_valid && allow;
   assign fifo_pop = !fifo_empty && (!hold_valid || load);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_valid <= 1'b0;
         hold_data  <= '0;
      end else if (fifo_pop) begin
         hold_valid <= 1'b1;
         hold_data  <= fifo_head;
      end else if (load) begin
         hold_valid <= 1'b0;
      end
   end

   assign hold_empty = !hold_valid;

   stx_shifter i_shift (
      .clk(clk), .rst_n(rst_n), .load(load), .data(hold_data),
      .fmt(fmt), .half_tick(half_tick), .busy(busy), .txd(txd)
   );

   AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_valid && !load) |=> hold_valid); // R7
   AST_START_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(allow)); // R8

endmodule

// File: tb/test_serial_tx_core.sv
module test_serial_tx_core;
   localparam int HD    = 3;
   localparam int DEPTH = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic [1:0] cfg_len = 2'd3, cfg_par = 2'd0, cfg_stop = 2'd0;
   logic cts = 1'b1;
   logic rx_valid = 1'b0;
   logic [7:0] rx_byte = '0;
   logic txd, fifo_full, hold_empty;

   int checks = 0;
   int errors = 0;
   bit checking = 1'b0;

   always #5 clk = ~clk;

   serial_tx_core #(.HALF_DIV(HD), .DEPTH(DEPTH), .FLOW_SW(1'b1)) i_serial_tx_core (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .cfg_len(cfg_len), .cfg_par(cfg_par), .cfg_stop(cfg_stop),
      .cts(cts), .rx_valid(rx_valid), .rx_byte(rx_byte),
      .txd(txd), .fifo_full(fifo_full), .hold_empty(hold_empty)
   );

   // ---------------- behavioural reference model ----------------
   byte unsigned q[$];
   bit         m_hold_v, m_busy, m_paused;
   logic [7:0] m_hold_d;
   int         m_el, m_tot, m_n, m_pe;
   bit         m_frame[12];
   logic [1:0] m_len, m_par, m_stop;

   always @(posedge clk) begin
      if (!rst_n) begin
         q.delete();
         m_hold_v = 0; m_busy = 0; m_paused = 0; m_el = 0; m_tot = 0;
         m_hold_d = '0; m_n = 8; m_pe = 0;
         m_len = '0; m_par = '0; m_stop = '0;
      end else begin
         bit ld, pu, po;
         int ones, sh_h;
         ld = !m_busy && m_hold_v && cts && !m_paused;
         pu = wr_en && (q.size() < DEPTH);
         po = (q.size() > 0) && (!m_hold_v || ld);
         if (ld) begin
            m_len = cfg_len; m_par = cfg_par; m_stop = cfg_stop;
            m_n = 5 + int'(cfg_len);
            ones = 0;
            for (int i = 0; i < 12; i++) m_frame[i] = 1'b1;
            m_frame[0] = 1'b0;
            for (int i = 0; i < m_n; i++) begin
               m_frame[1+i] = m_hold_d[i];
               ones += int'(m_hold_d[i]);
            end
            m_pe = (cfg_par == 2'd1 || cfg_par == 2'd2) ? 1 : 0;
            if (m_pe == 1) m_frame[m_n+1] = (cfg_par == 2'd1) ? (ones % 2 == 1) : (ones % 2 == 0);
            sh_h = (cfg_stop == 2'd0) ? 2 : (cfg_stop == 2'd1) ? 3 : 4;
            m_tot = (2 * (1 + m_n + m_pe) + sh_h) * HD;
            m_busy = 1; m_el = 0;
         end else if (m_busy) begin
            m_el++;
            if (m_el == m_tot) m_busy = 0;
         end
         if (po) begin
            m_hold_d = q.pop_front();
            m_hold_v = 1;
         end else if (ld) begin
            m_hold_v = 0;
         end
         if (pu) q.push_back(wr_data);
         if (rx_valid && rx_byte == 8'h13) m_paused = 1;
         else if (rx_valid && rx_byte == 8'h11) m_paused = 0;
      end
   end

   task automatic chk(input logic act, input logic exp, input string tag, input string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%b expected=%b at %0t", tag, what, act, exp, $time);
      end
   endtask

   // every-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (rst_n && checking) begin
         logic  exp_txd;
         string tag;
         int    idx;
         if (!m_busy) begin
            exp_txd = 1'b1;
            tag = m_paused ? "R9" : (!cts && m_hold_v) ? "R8" : "R1";
         end else begin
            idx = m_el / (2 * HD);
            exp_txd = m_frame[idx];
            if (cfg_len != m_len || cfg_par != m_par || cfg_stop != m_stop) tag = "R5";
            else if (idx == 0)                    tag = "R1";
            else if (idx <= m_n)                  tag = "R2";
            else if (idx == m_n + 1 && m_pe == 1) tag = "R3";
            else                                  tag = "R4";
         end
         chk(txd, exp_txd, tag, "txd");
         chk(fifo_full, q.size() == DEPTH, "R6", "fifo_full");
         chk(hold_empty, !m_hold_v, "R7", "hold_empty");
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic push(input logic [7:0] b);
      wr_en = 1'b1; wr_data = b;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rx(input logic [7:0] b);
      rx_valid = 1'b1; rx_byte = b;
      @(negedge clk);
      rx_valid = 1'b0;
   endtask

   task automatic fmt(input logic [1:0] l, input logic [1:0] p, input logic [1:0] s);
      cfg_len = l; cfg_par = p; cfg_stop = s;
   endtask

   task automatic drain();
      for (int k = 0; k < 5000; k++) begin
         @(negedge clk);
         if (!m_busy && !m_hold_v && q.size() == 0) return;
      end
      checks++; errors++;
      $display("FAIL R7 drain: actual=busy expected=idle");
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; errors++;
      $display("FAIL R7 watchdog: actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state
      chk(txd, 1'b1, "R1", "reset txd");
      chk(fifo_full, 1'b0, "R6", "reset fifo_full");
      chk(hold_empty, 1'b1, "R7", "reset hold_empty");
      checking = 1'b1;

      // R2 R4: 8 bits, no parity, one stop
      fmt(2'd3, 2'd0, 2'd0);
      push(8'h55); push(8'hA3);
      drain();
      // R3 R4: 7 bits even parity two stop
      fmt(2'd2, 2'd1, 2'd2); push(8'h5B); drain();
      // R3 R4: 5 bits odd parity one-and-half stop
      fmt(2'd0, 2'd2, 2'd1); push(8'h1F); drain();
      // R2 R3: 6 bits even parity
      fmt(2'd1, 2'd1, 2'd0); push(8'h2C); drain();
      // R3 R4: parity code 3 = none, stop code 3 = two
      fmt(2'd3, 2'd3, 2'd3); push(8'h81); drain();

      // R6 R8: fill while clear-to-send is low, extra writes dropped
      fmt(2'd3, 2'd0, 2'd0);
      cts = 1'b0;
      for (int i = 0; i < 7; i++) push(8'h10 + 8'(i));
      repeat (20) @(negedge clk);
      cts = 1'b1;
      // R5: change format in the middle of a character
      repeat (8) @(negedge clk);
      fmt(2'd0, 2'd2, 2'd1);
      repeat (30) @(negedge clk);
      fmt(2'd3, 2'd0, 2'd0);
      drain();

      // R9: pause during a character, unrelated byte, resume
      fmt(2'd3, 2'd1, 2'd0);
      push(8'hC4); push(8'h3A); push(8'h77);
      repeat (10) @(negedge clk);
      rx(8'h13);
      repeat (60) @(negedge clk);
      rx(8'h41);
      repeat (60) @(negedge clk);
      rx(8'h11);
      drain();

      // R8: clear-to-send dropped mid character
      fmt(2'd3, 2'd0, 2'd2);
      push(8'hE1); push(8'h0F);
      repeat (8) @(negedge clk);
      cts = 1'b0;
      repeat (100) @(negedge clk);
      cts = 1'b1;
      drain();
      repeat (4) @(negedge clk);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule